// File: doc/BRIEF.md
# Bit-Aligned Receive Byte Packer

This block sits after the demodulator of a contactless-card receiver. It takes a serial stream of received bits, one per strobe, with a start-of-frame strobe before the frame and an end-of-frame strobe after it. It packs the data bits least significant first into bytes and presents each byte to the write port of an external FIFO. When parity is enabled, every eighth data bit is followed by one odd-parity bit. The block consumes that bit and checks it, and never forwards it.

A 3-bit alignment register lets a frame start in the middle of a byte, which is how bit-oriented frames (for example an anticollision response that resumes after a known prefix) are received. With alignment N, the first byte carries only 8-N received bits, placed in its upper positions. The parity bit of that partial byte is not checked. When N is 7 the single-bit first byte is dropped. The alignment register clears itself at every end of frame. At end of frame a partially filled byte is flushed and the number of occupied bit positions in it is reported. A frame that ends where a parity bit was due is flagged as a framing error.

Top module: `rx_bit_packer`

## Requirements
- R1: With alignment 0, received data bits fill bytes from bit 0 upward (first bit received lands in bit 0), and each completed byte is written to the FIFO (fifo_wr_en high for one cycle) on the clock edge after its last data bit is sampled.
- R2: With alignment N in 1..6, the first byte written holds the first 8-N received bits in positions N..7 with positions 0..N-1 zero, and every later byte is a full 8-bit byte in arrival order.
- R3: With alignment 7, the first received bit forms a byte that is never written to the FIFO; the next written byte is built from the following eight data bits.
- R4: The alignment register (align_q) loads align_din on align_wr and reads 0 after every end of frame, with the clear winning over a simultaneous load.
- R5: With par_en sampled high at start of frame, each complete byte's eight data bits are followed by one parity bit that must make the count of ones odd; a mismatch sets parity_err, which stays set until the next start of frame clears it, and parity bits are never written to the FIFO.
- R6: When alignment is nonzero and parity is enabled, the parity bit after the first (partial) byte is not checked.
- R7: At end of frame a partially filled byte is written with its unfilled upper bits zero, and last_bits reports the index of the first unfilled bit position (1..7); last_bits is 0 when the final byte was complete. last_bits and rx_done update on the edge that samples the end-of-frame strobe.
- R8: With parity enabled, an end of frame that arrives after the eighth data bit of a byte but before its parity bit sets frame_err, which the next start of frame clears.
- R9: After reset fifo_wr_en, rx_done, frame_err and parity_err are low and last_bits and align_q are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_sof | input | 1 | Start-of-frame strobe, one cycle |
| rx_eof | input | 1 | End-of-frame strobe, one cycle |
| rx_bit_vld | input | 1 | A received bit is present on rx_bit |
| rx_bit | input | 1 | Received bit value (data or parity, by position) |
| par_en | input | 1 | Parity checking enable, sampled at start of frame |
| align_wr | input | 1 | Load strobe for the alignment register |
| align_din | input | 3 | New alignment value |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | 8 | Byte written to the FIFO |
| last_bits | output | 3 | Occupied bit positions in the final byte, 0 if complete |
| frame_err | output | 1 | Framing error of the last frame |
| parity_err | output | 1 | Sticky parity error of the current frame |
| align_q | output | 3 | Current alignment register value |
| rx_done | output | 1 | One-cycle pulse at end of frame |

## Verification
The assertions assume the front end never raises rx_eof or rx_sof in the same cycle as rx_bit_vld, that bits arrive only between a start and an end strobe, and that par_en and align_din are held steady around the start strobe. The directed tasks drive each strobe on its own clock cycle with idle gaps, load the alignment before starting a frame, and keep par_en constant across a frame. Under those conditions the properties on bit-position stepping, parity flag origin, flush contents and the post-frame alignment clear hold for every stimulus the tasks generate.

// File: rtl/rbp_pkg.sv
package rbp_pkg;
  localparam int unsigned RBP_BYTE_W = 8;

  typedef enum logic [1:0] {
    RX_IDLE   = 2'd0,
    RX_DATA   = 2'd1,
    RX_PARITY = 2'd2
  } rx_phase_e;
endpackage

// File: rtl/rbp_align_reg.sv
module rbp_align_reg #(
  parameter int unsigned POS_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [POS_W-1:0] wr_val,
  input  logic             clr,
  output logic [POS_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (clr) begin
      q <= '0;
    end else if (wr) begin
      q <= wr_val;
    end
  end

  // R4
  align_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0));
endmodule

// File: rtl/rbp_byte_asm.sv
module rbp_byte_asm #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned POS_W  = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [POS_W-1:0]  start_pos,
  input  logic              data_stb,
  input  logic              data_bit,
  output logic              done,
  output logic [BYTE_W-1:0] done_byte,
  output logic [BYTE_W-1:0] part_byte,
  output logic [POS_W-1:0]  pos,
  output logic              has_bits
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] acc_q;
  logic [POS_W-1:0]  pos_q;
  logic              has_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      pos_q <= '0;
      has_q <= 1'b0;
    end else if (start) begin
      acc_q <= '0;
      pos_q <= start_pos;
      has_q <= 1'b0;
    end else if (data_stb) begin
      if (pos_q == LAST_POS) begin
        acc_q <= '0;
        pos_q <= '0;
        has_q <= 1'b0;
      end else begin
        acc_q[pos_q] <= data_bit;
        pos_q        <= pos_q + POS_W'(1);
        has_q        <= 1'b1;
      end
    end
  end

  always_comb begin
    done      = data_stb && (pos_q == LAST_POS);
    done_byte = {data_bit, acc_q[BYTE_W-2:0]};
    part_byte = acc_q;
    pos       = pos_q;
    has_bits  = has_q;
  end

  // R2
  pos_step_chk: assert property (@(posedge clk) disable iff (rst)
    (data_stb && !start && pos_q != LAST_POS) |=> (pos_q == $past(pos_q) + POS_W'(1)) && has_q);

  // R1
  pos_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (data_stb && !start && pos_q == LAST_POS) |=> (pos_q == '0) && !has_q);
endmodule

// File: rtl/rbp_parity_chk.sv
module rbp_parity_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              skip_in,
  input  logic              chk,
  input  logic              par_bit,
  output logic              err
);
  logic exp_q;
  logic skip_q;
  logic err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q  <= 1'b0;
      skip_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (load) begin
        exp_q  <= ~(^byte_in);
        skip_q <= skip_in;
      end
      if (clr) begin
        err_q <= 1'b0;
      end else if (chk && !skip_q && (par_bit != exp_q)) begin
        err_q <= 1'b1;
      end
    end
  end

  assign err = err_q;

  // R6
  par_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> $past(chk && !skip_q));

  // R5
  par_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !err_q);
endmodule

// File: rtl/rx_bit_packer.sv
module rx_bit_packer #(
  parameter int unsigned BYTE_W = rbp_pkg::RBP_BYTE_W,
  parameter int unsigned POS_W  = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_bit_vld,
  input  logic              rx_bit,
  input  logic              par_en,
  input  logic              align_wr,
  input  logic [POS_W-1:0]  align_din,
  output logic              fifo_wr_en,
  output logic [BYTE_W-1:0] fifo_wr_data,
  output logic [POS_W-1:0]  last_bits,
  output logic              frame_err,
  output logic              parity_err,
  output logic [POS_W-1:0]  align_q,
  output logic              rx_done
);
  import rbp_pkg::*;

  localparam logic [POS_W-1:0] MAX_ALIGN = POS_W'(BYTE_W - 1);

  rx_phase_e         phase_q;
  logic              par_en_q;
  logic [POS_W-1:0]  align_cur_q;
  logic              first_q;

  logic              data_stb;
  logic              par_stb;
  logic              eof_evt;
  logic              byte_done;
  logic [BYTE_W-1:0] done_byte;
  logic [BYTE_W-1:0] part_byte;
  logic [POS_W-1:0]  cur_pos;
  logic              cur_has;
  logic              suppress;
  logic              skip_par;

  always_comb begin
    data_stb = (phase_q == RX_DATA) && rx_bit_vld && !rx_eof && !rx_sof;
    par_stb  = (phase_q == RX_PARITY) && rx_bit_vld && !rx_eof && !rx_sof;
    eof_evt  = (phase_q != RX_IDLE) && rx_eof && !rx_sof;
    suppress = first_q && (align_cur_q == MAX_ALIGN);
    skip_par = first_q && (align_cur_q != '0);
  end

  rbp_align_reg #(.POS_W(POS_W)) i_align (
    .clk    (clk),
    .rst    (rst),
    .wr     (align_wr),
    .wr_val (align_din),
    .clr    (eof_evt),
    .q      (align_q)
  );

  rbp_byte_asm #(.BYTE_W(BYTE_W), .POS_W(POS_W)) i_asm (
    .clk       (clk),
    .rst       (rst),
    .start     (rx_sof),
    .start_pos (align_q),
    .data_stb  (data_stb),
    .data_bit  (rx_bit),
    .done      (byte_done),
    .done_byte (done_byte),
    .part_byte (part_byte),
    .pos       (cur_pos),
    .has_bits  (cur_has)
  );

  rbp_parity_chk #(.BYTE_W(BYTE_W)) i_par (
    .clk     (clk),
    .rst     (rst),
    .clr     (rx_sof),
    .load    (byte_done),
    .byte_in (done_byte),
    .skip_in (skip_par),
    .chk     (par_stb),
    .par_bit (rx_bit),
    .err     (parity_err)
  );

  // frame sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= RX_IDLE;
      par_en_q    <= 1'b0;
      align_cur_q <= '0;
      first_q     <= 1'b0;
    end else if (rx_sof) begin
      phase_q     <= RX_DATA;
      par_en_q    <= par_en;
      align_cur_q <= align_q;
      first_q     <= 1'b1;
    end else if (eof_evt) begin
      phase_q <= RX_IDLE;
      first_q <= 1'b0;
    end else if (byte_done) begin
      first_q <= 1'b0;
      if (par_en_q) begin
        phase_q <= RX_PARITY;
      end
    end else if (par_stb) begin
      phase_q <= RX_DATA;
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_wr_en   <= 1'b0;
      fifo_wr_data <= '0;
      last_bits    <= '0;
      frame_err    <= 1'b0;
      rx_done      <= 1'b0;
    end else begin
      fifo_wr_en <= 1'b0;
      rx_done    <= 1'b0;
      if (rx_sof) begin
        frame_err <= 1'b0;
      end else if (eof_evt) begin
        rx_done   <= 1'b1;
        frame_err <= (phase_q == RX_PARITY);
        if ((phase_q == RX_DATA) && cur_has) begin
          fifo_wr_en   <= 1'b1;
          fifo_wr_data <= part_byte;
          last_bits    <= cur_pos;
        end else begin
          last_bits <= '0;
        end
      end else if (byte_done && !suppress) begin
        fifo_wr_en   <= 1'b1;
        fifo_wr_data <= done_byte;
      end
    end
  end

  // R1
  wr_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_en |-> $past(phase_q != RX_IDLE));

  // R7
  flush_zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_done && fifo_wr_en && last_bits != '0) |-> ((fifo_wr_data >> last_bits) == '0));

  // R7
  flush_write_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_done && last_bits != '0) |-> fifo_wr_en);

  // R8
  frame_err_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_err) |-> rx_done);

  // R4
  done_align_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> (align_q == '0));
endmodule

// File: tb/test_rx_bit_packer.sv
module test_rx_bit_packer;
  logic       clk = 1'b0;
  logic       rst;
  logic       rx_sof, rx_eof, rx_bit_vld, rx_bit, par_en, align_wr;
  logic [2:0] align_din;
  logic       fifo_wr_en;
  logic [7:0] fifo_wr_data;
  logic [2:0] last_bits;
  logic       frame_err, parity_err, rx_done;
  logic [2:0] align_q;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  logic [7:0] got[$];
  logic [2:0] s_last;
  logic       s_done, s_ferr;
  logic [2:0] s_align;

  always #4 clk = ~clk;

  rx_bit_packer i_rx_bit_packer (
    .clk(clk), .rst(rst), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_bit_vld(rx_bit_vld), .rx_bit(rx_bit), .par_en(par_en),
    .align_wr(align_wr), .align_din(align_din),
    .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
    .last_bits(last_bits), .frame_err(frame_err), .parity_err(parity_err),
    .align_q(align_q), .rx_done(rx_done)
  );

  always @(negedge clk) if (fifo_wr_en) got.push_back(fifo_wr_data);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_bytes(input string tag, input logic [7:0] exp[$]);
    check(got.size() == exp.size(), {tag, " byte count"}, got.size(), exp.size());
    foreach (exp[i]) begin
      if (i < got.size()) check(got[i] == exp[i], {tag, " byte value"}, got[i], exp[i]);
    end
  endtask

  task automatic begin_frame(input logic [2:0] a, input logic pen);
    got.delete();
    align_wr = 1'b1; align_din = a;
    @(negedge clk);
    align_wr = 1'b0;
    check(align_q == a, "R4 align load", align_q, a);
    par_en = pen; rx_sof = 1'b1;
    @(negedge clk);
    rx_sof = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    rx_bit_vld = 1'b1; rx_bit = b;
    @(negedge clk);
    rx_bit_vld = 1'b0;
  endtask

  task automatic send_data(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) send_bit(v[i]);
  endtask

  task automatic end_frame;
    rx_eof = 1'b1;
    @(negedge clk);
    rx_eof = 1'b0;
    s_done = rx_done; s_last = last_bits; s_ferr = frame_err; s_align = align_q;
    #2;
    check(s_done == 1'b1, "R7 rx_done pulse", s_done, 1);
    check(s_align == 3'd0, "R4 align auto-clear", s_align, 0);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check(fifo_wr_en == 1'b0 && rx_done == 1'b0, "R9 strobes idle", fifo_wr_en, 0);
    check(frame_err == 1'b0 && parity_err == 1'b0, "R9 flags clear", {frame_err, parity_err}, 0);
    check(last_bits == 3'd0 && align_q == 3'd0, "R9 counters zero", {last_bits, align_q}, 0);
  endtask

  task automatic t_plain;
    begin_frame(3'd0, 1'b0);
    send_data(8'hA5, 8);
    send_data(8'h3C, 8);
    end_frame();
    check_bytes("R1 plain bytes", '{8'hA5, 8'h3C});
    check(s_last == 3'd0, "R7 complete last byte", s_last, 0);
  endtask

  task automatic t_align3;
    begin_frame(3'd3, 1'b0);
    send_data(8'h0D, 5);
    send_data(8'h81, 8);
    end_frame();
    check_bytes("R2 offset 3", '{8'h68, 8'h81});
    check(s_last == 3'd0, "R7 last after offset", s_last, 0);
  endtask

  task automatic t_partial;
    begin_frame(3'd0, 1'b0);
    send_data(8'h5A, 8);
    send_data(8'h09, 4);
    end_frame();
    check_bytes("R7 flush partial", '{8'h5A, 8'h09});
    check(s_last == 3'd4, "R7 last_bits 4", s_last, 4);
  endtask

  task automatic t_align7;
    begin_frame(3'd7, 1'b0);
    send_data(8'h01, 1);
    send_data(8'hC3, 8);
    end_frame();
    check_bytes("R3 single bit dropped", '{8'hC3});
  endtask

  task automatic t_parity;
    begin_frame(3'd0, 1'b1);
    send_data(8'h01, 8); send_bit(1'b0);
    send_data(8'h03, 8); send_bit(1'b1);
    end_frame();
    check_bytes("R5 parity good", '{8'h01, 8'h03});
    check(parity_err == 1'b0, "R5 no parity error", parity_err, 0);
    begin_frame(3'd0, 1'b1);
    send_data(8'h03, 8); send_bit(1'b0);
    check(parity_err == 1'b1, "R5 parity mismatch", parity_err, 1);
    end_frame();
    check(parity_err == 1'b1, "R5 sticky", parity_err, 1);
  endtask

  task automatic t_skip;
    begin_frame(3'd2, 1'b1);
    check(parity_err == 1'b0, "R5 cleared at sof", parity_err, 0);
    send_data(8'h3F, 6); send_bit(1'b0);
    send_data(8'h80, 8); send_bit(1'b0);
    end_frame();
    check_bytes("R6 first parity skipped", '{8'hFC, 8'h80});
    check(parity_err == 1'b0, "R6 no error on skipped", parity_err, 0);
  endtask

  task automatic t_frame_err;
    begin_frame(3'd0, 1'b1);
    send_data(8'h55, 8);
    end_frame();
    check(s_ferr == 1'b1, "R8 missing parity", s_ferr, 1);
    check_bytes("R8 byte still written", '{8'h55});
    begin_frame(3'd0, 1'b1);
    check(frame_err == 1'b0, "R8 cleared at sof", frame_err, 0);
    send_data(8'hF0, 8); send_bit(1'b1);
    send_data(8'h05, 3);
    end_frame();
    check(s_ferr == 1'b0, "R8 partial tail ok", s_ferr, 0);
    check(s_last == 3'd3, "R7 last_bits 3 with parity", s_last, 3);
    check_bytes("R7 parity frame flush", '{8'hF0, 8'h05});
  endtask

  initial begin
    rst = 1'b1; rx_sof = 0; rx_eof = 0; rx_bit_vld = 0; rx_bit = 0;
    par_en = 0; align_wr = 0; align_din = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_align3();
    t_partial();
    t_align7();
    t_parity();
    t_skip();
    t_frame_err();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule